// File: doc/BRIEF.md
# Predicated Floating-Point Min/Max Tree Reducer

This block collapses one vector register of IEEE 754 elements into a single scalar. The elements may be half, single or double precision. The reduction is one of four comparisons: minimum, maximum, and the NaN-skipping minNum and maxNum. A per-byte predicate and an active vector length in bytes choose which lanes take part. Every lane that does not take part is replaced by the identity of the selected operation. All lanes then pass through a balanced pairwise tree, so the outcome always follows one fixed lower-half/upper-half combination order.

A caller presents the vector, the predicate, a size code, an operation code and the length, and pulses start for one cycle. One cycle later the done strobe rises for one cycle. The result is zero-extended to 64 bits. A reject flag is raised with done when the request is illegal.

Top module: `fpred_reduce`

## Requirements
- R1: A size code of 0 (byte elements) is rejected. One cycle after start, done and reject are both 1 and the result is 0. Size codes 1, 2 and 3 select 16-, 32- and 64-bit elements.
- R2: An operation code whose bit 2 is 0 (for example 000, the add reduction, or 011) is rejected in the same way as R1. The legal codes are 100 maxNum, 101 minNum, 110 max and 111 min.
- R3: done is 1 in exactly the cycle after each cycle in which start is 1, so back-to-back starts give back-to-back results. After reset, done, reject and the result are all 0.
- R4: min returns the numerically smallest active element, and treats -0 as smaller than +0.
- R5: max returns the numerically largest active element, and treats +0 as larger than -0.
- R6: For min and max, a NaN in any active lane makes the result the default NaN: 0x7E00 for half, 0x7FC00000 for single and 0x7FF8000000000000 for double.
- R7: For minNum and maxNum, a quiet NaN operand is passed over in favour of the numeric operand. Two NaN operands, or any signalling NaN (exponent all ones, top mantissa bit 0, mantissa nonzero), give the default NaN.
- R8: Lane i of an element of E bytes is active only when predicate bit i*E is 1. The other predicate bits have no effect.
- R9: Lane i takes part only when (i+1)*E is no greater than the active vector length in bytes. Lanes beyond that length act as inactive.
- R10: An inactive lane contributes the identity of the operation: +infinity for min, -infinity for max and the default NaN for minNum and maxNum. When no lane is active, the result equals that identity.
- R11: The element in lane i occupies data bits [i*8E +: 8E]. The scalar result sits in the low bits of the 64-bit output, and the bits above it are zero.
- R12: Lanes are combined in a balanced tree of adjacent pairs. Each node combines its lower input with its upper input, and level k pairs the results of level k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a reduction of the present inputs |
| size_i | input | 2 | Element size code |
| op_i | input | 3 | Reduction operation code |
| vlen_i | input | $clog2(VBYTES)+1 | Active vector length in bytes |
| pred_i | input | VBYTES | One predicate bit per data byte |
| data_i | input | VBYTES*8 | Vector elements, lane 0 in the low bits |
| result_o | output | 64 | Zero-extended scalar result |
| done_o | output | 1 | One-cycle strobe, result valid |
| reject_o | output | 1 | Request was illegal, valid with done |

## Verification
The bench builds the block with VBYTES set to 32. That gives 16 half, 8 single and 4 double lanes, so every lane of every tree can be written by hand. At this width a single vector can hold a signalling NaN at a chosen tree position. It also allows length values that stop exactly on a lane boundary and fill patterns that use only the odd predicate bits. The order-dependent minNum case, where the tree result differs from a left-to-right fold, can therefore be checked directly.

// File: rtl/fpred_pkg.sv
package fpred_pkg;

   // element size codes
   localparam logic [1:0] SZ_BYTE   = 2'd0;
   localparam logic [1:0] SZ_HALF   = 2'd1;
   localparam logic [1:0] SZ_SINGLE = 2'd2;
   localparam logic [1:0] SZ_DOUBLE = 2'd3;

   // operation codes; bit 2 set marks the comparison family
   localparam logic [2:0] OPC_MAXNUM = 3'b100;
   localparam logic [2:0] OPC_MINNUM = 3'b101;
   localparam logic [2:0] OPC_MAX    = 3'b110;
   localparam logic [2:0] OPC_MIN    = 3'b111;

   // exponent field width for a given IEEE element width
   function automatic int exp_width(input int w);
      if (w == 16) return 5;
      if (w == 32) return 8;
      return 11;
   endfunction

   function automatic logic op_supported(input logic [2:0] op);
      return op[2];
   endfunction

endpackage

// File: rtl/fpred_node.sv
// One combining node: mode[1]=1 strict min/max, 0 NaN-skipping; mode[0]=1 min.
module fpred_node #(
   parameter int W    = 32,
   parameter int EXPW = 8
) (
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] hi_i,
   input  logic [1:0]   mode_i,
   output logic [W-1:0] y_o
);
   localparam int MW = W - 1 - EXPW;
   localparam logic [W-1:0] DNAN = {1'b0, {EXPW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

   if (MW < 2) begin : g_bad_fmt
      $error("fpred_node: mantissa too narrow");
   end

   logic          lo_nan, hi_nan, lo_sig, hi_sig, lo_less;
   logic [W-1:0]  lo_key, hi_key, ordered;

   always_comb begin
      lo_nan  = (&lo_i[W-2:MW]) && (|lo_i[MW-1:0]);
      hi_nan  = (&hi_i[W-2:MW]) && (|hi_i[MW-1:0]);
      lo_sig  = lo_nan && !lo_i[MW-1];
      hi_sig  = hi_nan && !hi_i[MW-1];
      // monotone unsigned key: negative values inverted, positive values offset
      lo_key  = lo_i[W-1] ? ~lo_i : {1'b1, lo_i[W-2:0]};
      hi_key  = hi_i[W-1] ? ~hi_i : {1'b1, hi_i[W-2:0]};
      lo_less = lo_key < hi_key;
      ordered = (mode_i[0] == lo_less) ? lo_i : hi_i;
      if (mode_i[1]) begin
         y_o = (lo_nan || hi_nan) ? DNAN : ordered;
      end else if (lo_sig || hi_sig || (lo_nan && hi_nan)) begin
         y_o = DNAN;
      end else if (lo_nan) begin
         y_o = hi_i;
      end else if (hi_nan) begin
         y_o = lo_i;
      end else begin
         y_o = ordered;
      end
   end

endmodule

// File: rtl/fpred_tree.sv
// Identity masking of lanes followed by a balanced tree of adjacent pairs.
module fpred_tree #(
   parameter int W     = 32,
   parameter int EXPW  = 8,
   parameter int LANES = 8
) (
   input  logic [LANES*W-1:0] vec_i,
   input  logic [LANES-1:0]   act_i,
   input  logic [1:0]         mode_i,
   output logic [W-1:0]       res_o
);
   localparam int DEPTH = $clog2(LANES);
   localparam int MW    = W - 1 - EXPW;
   localparam logic [W-1:0] POS_INF = {1'b0, {EXPW{1'b1}}, {MW{1'b0}}};
   localparam logic [W-1:0] NEG_INF = {1'b1, {EXPW{1'b1}}, {MW{1'b0}}};
   localparam logic [W-1:0] DNAN    = {1'b0, {EXPW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

   if (LANES < 2 || (1 << DEPTH) != LANES) begin : g_bad_lanes
      $error("fpred_tree: LANES must be a power of two of at least 2");
   end

   logic [W-1:0] fill;
   always_comb begin
      if (!mode_i[1])     fill = DNAN;
      else if (mode_i[0]) fill = POS_INF;
      else                fill = NEG_INF;
   end

   for (genvar l = 0; l <= DEPTH; l++) begin : lvl_g
      localparam int N = LANES >> l;
      logic [W-1:0] v [N];
      if (l == 0) begin : g_leaf
         for (genvar i = 0; i < N; i++) begin : g_lane
            assign v[i] = act_i[i] ? vec_i[i*W +: W] : fill;
         end
      end else begin : g_comb
         for (genvar j = 0; j < N; j++) begin : g_pair
            fpred_node #(.W(W), .EXPW(EXPW)) u_node (
               .lo_i   (lvl_g[l-1].v[2*j]),
               .hi_i   (lvl_g[l-1].v[2*j+1]),
               .mode_i (mode_i),
               .y_o    (v[j])
            );
         end
      end
   end

   assign res_o = lvl_g[DEPTH].v[0];

endmodule

// File: rtl/fpred_reduce.sv
module fpred_reduce #(
   parameter int VBYTES = 256
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       start_i,
   input  logic [1:0]                 size_i,
   input  logic [2:0]                 op_i,
   input  logic [$clog2(VBYTES):0]    vlen_i,
   input  logic [VBYTES-1:0]          pred_i,
   input  logic [VBYTES*8-1:0]        data_i,
   output logic [63:0]                result_o,
   output logic                       done_o,
   output logic                       reject_o
);
   import fpred_pkg::*;

   localparam int VLW = $clog2(VBYTES) + 1;
   localparam logic [VBYTES-1:0] ODD_MASK = {(VBYTES/2){2'b10}};

   if (VBYTES < 16 || (1 << $clog2(VBYTES)) != VBYTES) begin : g_bad_vbytes
      $error("fpred_reduce: VBYTES must be a power of two of at least 16");
   end

   // predicate bits at odd byte offsets never govern a lane
   logic unused_pred_odd;
   assign unused_pred_odd = ^(pred_i & ODD_MASK);

   logic [63:0] red_all [3];

   for (genvar k = 0; k < 3; k++) begin : sz_g
      localparam int EB    = 2 << k;
      localparam int W     = EB * 8;
      localparam int LANES = VBYTES / EB;
      localparam int EXPW  = exp_width(W);
      logic [LANES-1:0] act;
      logic [W-1:0]     red;
      for (genvar i = 0; i < LANES; i++) begin : g_act
         localparam logic [VLW-1:0] LIM = VLW'((i + 1) * EB);
         assign act[i] = pred_i[i*EB] && (vlen_i >= LIM);
      end
      fpred_tree #(.W(W), .EXPW(EXPW), .LANES(LANES)) u_tree (
         .vec_i  (data_i),
         .act_i  (act),
         .mode_i (op_i[1:0]),
         .res_o  (red)
      );
      assign red_all[k] = 64'(red);
   end

   logic        legal;
   logic [63:0] pick;
   always_comb begin
      legal = (size_i != SZ_BYTE) && op_supported(op_i);
      case (size_i)
         SZ_HALF:   pick = red_all[0];
         SZ_SINGLE: pick = red_all[1];
         SZ_DOUBLE: pick = red_all[2];
         default:   pick = '0;
      endcase
   end

   logic [63:0] res_q;
   logic        done_q, rej_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_q  <= '0;
         done_q <= 1'b0;
         rej_q  <= 1'b0;
      end else begin
         done_q <= start_i;
         rej_q  <= start_i && !legal;
         if (start_i) res_q <= legal ? pick : '0;
      end
   end

   assign result_o = res_q;
   assign done_o   = done_q;
   assign reject_o = rej_q;

   a_r1_byte_size_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && size_i == SZ_BYTE) |=> (done_o && reject_o && result_o == 64'd0));

   a_r2_bad_op_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !op_i[2]) |=> (done_o && reject_o && result_o == 64'd0));

   a_r3_reject_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reject_o |-> done_o);

   a_r10_empty_single_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && size_i == SZ_SINGLE && op_i == OPC_MIN && pred_i == '0)
      |=> (result_o == 64'h0000_0000_7F80_0000));

   a_r11_half_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && size_i == SZ_HALF) |=> (result_o[63:16] == 48'd0));

endmodule

// File: tb/fpred_reduce_bench.sv
`timescale 1ns/1ps
module fpred_reduce_bench;
   localparam int VB = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    size = 2'd0;
   logic [2:0]    op = 3'd0;
   logic [5:0]    vlen = 6'd0;
   logic [31:0]   pred = '0;
   logic [255:0]  data = '0;
   logic [255:0]  vec = '0;
   logic [63:0]   result;
   logic          done, reject;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fpred_reduce #(.VBYTES(VB)) u_fpred_reduce (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .op_i(op),
      .vlen_i(vlen), .pred_i(pred), .data_i(data),
      .result_o(result), .done_o(done), .reject_o(reject)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic put_h(input int i, input logic [15:0] v); vec[i*16 +: 16] = v; endtask
   task automatic put_s(input int i, input logic [31:0] v); vec[i*32 +: 32] = v; endtask
   task automatic put_d(input int i, input logic [63:0] v); vec[i*64 +: 64] = v; endtask
   task automatic fill_h(input logic [15:0] v); for (int i = 0; i < 16; i++) put_h(i, v); endtask
   task automatic fill_s(input logic [31:0] v); for (int i = 0; i < 8; i++) put_s(i, v); endtask

   // one request; returns at the falling edge after the capturing edge
   task automatic go(input logic [1:0] sz, input logic [2:0] opc, input logic [5:0] vl,
                     input logic [31:0] pr);
      @(negedge clk);
      size = sz; op = opc; vlen = vl; pred = pr; data = vec; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic t_reset;
      chk("R3 reset done", {63'd0, done}, 64'd0);
      chk("R3 reset reject", {63'd0, reject}, 64'd0);
      chk("R3 reset result", result, 64'd0);
   endtask

   task automatic t_min_max_half;
      fill_h(16'h4200); put_h(7, 16'h4500); put_h(11, 16'hC000); put_h(3, 16'hBC00);
      go(2'd1, 3'b111, 6'd32, 32'hFFFF_FFFF);
      chk("R4 R11 half min", result, 64'h0000_0000_0000_C000);
      chk("R3 done after start", {63'd0, done}, 64'd1);
      @(negedge clk);
      chk("R3 done one cycle", {63'd0, done}, 64'd0);
      fill_h(16'h0000); put_h(9, 16'h8000);
      go(2'd1, 3'b111, 6'd32, 32'hFFFF_FFFF);
      chk("R4 min -0 below +0", result, 64'h8000);
      go(2'd1, 3'b110, 6'd32, 32'hFFFF_FFFF);
      chk("R5 max +0 above -0", result, 64'h0000);
   endtask

   task automatic t_single;
      put_s(0, 32'h3F80_0000); put_s(1, 32'h4040_0000); put_s(2, 32'h40A0_0000);
      put_s(3, 32'h4110_0000); put_s(4, 32'hC080_0000); put_s(5, 32'h3F80_0000);
      put_s(6, 32'h3F80_0000); put_s(7, 32'h3F80_0000);
      go(2'd2, 3'b110, 6'd32, 32'hFFFF_FFFF);
      chk("R5 single max", result, 64'h4110_0000);
      fill_s(32'h40A0_0000); put_s(1, 32'h7FC0_0123); put_s(2, 32'h4040_0000);
      go(2'd2, 3'b101, 6'd32, 32'hFFFF_FFFF);
      chk("R7 minnum skips qnan", result, 64'h4040_0000);
      fill_s(32'h7FC0_0123);
      go(2'd2, 3'b100, 6'd32, 32'hFFFF_FFFF);
      chk("R7 maxnum all nan", result, 64'h7FC0_0000);
   endtask

   task automatic t_nan_double;
      put_d(0, 64'h3FF0_0000_0000_0000); put_d(1, 64'h4000_0000_0000_0000);
      put_d(2, 64'h7FF8_0000_0000_0123); put_d(3, 64'hC008_0000_0000_0000);
      go(2'd3, 3'b111, 6'd32, 32'hFFFF_FFFF);
      chk("R6 min nan double", result, 64'h7FF8_0000_0000_0000);
      go(2'd3, 3'b111, 6'd32, 32'h0100_0101);
      chk("R8 nan lane predicated off", result, 64'hC008_0000_0000_0000);
   endtask

   task automatic t_pred;
      fill_h(16'h4000); put_h(1, 16'hC000);
      go(2'd1, 3'b111, 6'd32, 32'hFFFF_FFFB);
      chk("R8 lane bit at lowest byte", result, 64'h4000);
      go(2'd1, 3'b111, 6'd32, 32'hAAAA_AAAA);
      chk("R8 odd bits ignored", result, 64'h7C00);
   endtask

   task automatic t_vlen;
      fill_s(32'h40A0_0000); put_s(2, 32'h3F80_0000); put_s(5, 32'hC080_0000);
      go(2'd2, 3'b111, 6'd16, 32'hFFFF_FFFF);
      chk("R9 vlen 16", result, 64'h3F80_0000);
      go(2'd2, 3'b111, 6'd20, 32'hFFFF_FFFF);
      chk("R9 vlen 20 boundary", result, 64'h3F80_0000);
      go(2'd2, 3'b111, 6'd24, 32'hFFFF_FFFF);
      chk("R9 vlen 24", result, 64'hC080_0000);
   endtask

   task automatic t_empty;
      go(2'd3, 3'b110, 6'd32, 32'h0000_0000);
      chk("R10 empty max double", result, 64'hFFF0_0000_0000_0000);
      go(2'd1, 3'b101, 6'd32, 32'h0000_0000);
      chk("R10 empty minnum half", result, 64'h7E00);
      go(2'd2, 3'b111, 6'd0, 32'hFFFF_FFFF);
      chk("R10 zero length min single", result, 64'h7F80_0000);
   endtask

   task automatic t_reject;
      fill_s(32'h3F80_0000);
      go(2'd0, 3'b111, 6'd32, 32'hFFFF_FFFF);
      chk("R1 byte size reject", {62'd0, done, reject}, 64'd3);
      chk("R1 byte size result", result, 64'd0);
      go(2'd2, 3'b111, 6'd32, 32'hFFFF_FFFF);
      go(2'd2, 3'b000, 6'd32, 32'hFFFF_FFFF);
      chk("R2 add op reject", {62'd0, done, reject}, 64'd3);
      chk("R2 add op result", result, 64'd0);
      go(2'd2, 3'b011, 6'd32, 32'hFFFF_FFFF);
      chk("R2 op 011 reject", {63'd0, reject}, 64'd1);
   endtask

   task automatic t_order;
      put_s(0, 32'h40A0_0000); put_s(1, 32'h3F80_0000); put_s(2, 32'h7F80_0001);
      put_s(3, 32'h4040_0000);
      for (int i = 4; i < 8; i++) put_s(i, 32'h4110_0000);
      go(2'd2, 3'b101, 6'd32, 32'hFFFF_FFFF);
      chk("R12 pairwise order with snan", result, 64'h3F80_0000);
      go(2'd2, 3'b111, 6'd32, 32'hFFFF_FFFF);
      chk("R6 min snan", result, 64'h7FC0_0000);
   endtask

   task automatic t_back_to_back;
      fill_h(16'h4200); put_h(0, 16'h3C00); put_h(15, 16'h4500);
      @(negedge clk);
      size = 2'd1; vlen = 6'd32; pred = '1; data = vec; op = 3'b111; start = 1'b1;
      @(negedge clk);
      op = 3'b110;
      chk("R3 b2b first done", {63'd0, done}, 64'd1);
      chk("R3 b2b first result", result, 64'h3C00);
      @(negedge clk);
      start = 1'b0;
      chk("R3 b2b second done", {63'd0, done}, 64'd1);
      chk("R3 b2b second result", result, 64'h4500);
      @(negedge clk);
      chk("R3 b2b done falls", {63'd0, done}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_min_max_half();
      t_single();
      t_nan_double();
      t_pred();
      t_vlen();
      t_empty();
      t_reject();
      t_order();
      t_back_to_back();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      #80000;
      if (!finished) begin
         finished = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

endmodule